// File: doc/BRIEF.md
# Parallel Register-Update ALU Array

This block executes the update microinstructions that a stateful transition table returns for one packet. The bundle holds several instruction slots. Each slot names an opcode, two source operands and one destination register. A source can be a per-flow register, a global register, a parsed header field or a small immediate. The destination is either a per-flow register or a global register. Every slot has its own ALU, and all slots run at once. Each slot performs exactly one operation per packet, and no result feeds another slot within the same packet.

The block takes the instruction bundle together with the packet's current per-flow registers, global registers and header fields. Two clock cycles later it returns three things: the complete per-flow register set, ready to be written back to the flow context, and, for the global registers, a data vector with one write enable per register. The first cycle decodes the slots and fetches the operands. The second cycle runs the ALUs, resolves destination collisions and registers the results. A new packet can be accepted in every cycle.

Top module: `flow_alu_array`

## Requirements
- R1: A packet accepted with `in_valid` high at a rising edge produces `out_valid` high for exactly one cycle, after the second rising edge that follows. `out_valid` is never high without such a packet. Packets may arrive on consecutive cycles.
- R2: Slot s occupies bits [s*21+20 : s*21] of `in_instr`. Inside a slot: opcode [20:17], source A type [16:15], source A index [14:11], source B type [10:9], source B index [8:5], destination-is-global flag [4] (0 = per-flow, 1 = global), destination index [3:0].
- R3: Operand type codes are 0 = per-flow register, 1 = global register, 2 = header field, 3 = immediate. An immediate operand is the 4-bit index, zero-extended to 32 bits.
- R4: Opcode 1 (ADD) and opcode 2 (SUB, A minus B) wrap modulo 2^32.
- R5: Opcode 3 is AND, 4 is OR, 5 is XOR, 6 shifts A left and 7 shifts A right (logical). Both shifts use the amount in bits [4:0] of B. Opcode 8 returns the unsigned minimum of A and B, and opcode 9 the unsigned maximum.
- R6: Opcode 0 (NOP) and the unused opcodes 10 to 15 write no register and raise no global write enable.
- R7: A slot with a per-flow destination replaces that register in `flow_out`. Every per-flow register that no slot writes comes out equal to its `flow_in` value.
- R8: A slot with a global destination drives that register's word in `glob_wdata` and raises its bit in `glob_we`. A global register that no slot writes has its `glob_we` bit low, and its `glob_wdata` word equals its `glob_in` value.
- R9: When several slots write the same destination register, the result of the highest-numbered slot is the one that appears.
- R10: Every operand is read from the register values the packet came with. A slot never sees another slot's result from the same packet.
- R11: `glob_we` is all zeros whenever `out_valid` is low. `flow_out` and `glob_wdata` hold their values between packets.
- R12: While reset is active, and after it until the first packet, `out_valid`, `flow_out`, `glob_wdata` and `glob_we` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A packet's instruction bundle and registers are present |
| in_instr | input | NS*21 | Instruction bundle, one 21-bit field per slot |
| flow_in | input | 16*W | Packet's current per-flow registers, register i at [i*W +: W] |
| glob_in | input | 16*W | Current global registers |
| hdr_in | input | 16*W | Parsed header fields usable as operands |
| out_valid | output | 1 | Results of a packet are present |
| flow_out | output | 16*W | Updated per-flow register set for write-back |
| glob_wdata | output | 16*W | Write data for the global registers |
| glob_we | output | 16 | Write enable for each global register |

## Verification
Two functions can land in the same cycle: the resolution of a destination collision between slots, and the snapshot rule for operands. The case arises when one slot reads a register that another slot writes in the same packet. The bench provokes it with a directed packet in which a slot increments a per-flow register while a second slot reads that register, and two slots write the same global register. It also provokes it with random bundles whose indices are biased toward a few low registers. The bench judges each packet against a model that reads every operand from the unmodified inputs and applies the writes in ascending slot order.

// File: rtl/flow_alu_pkg.sv
package flow_alu_pkg;
   localparam int OPC_W = 4;
   localparam int TYP_W = 2;

   localparam logic [3:0] OPC_NOP = 4'd0;
   localparam logic [3:0] OPC_ADD = 4'd1;
   localparam logic [3:0] OPC_SUB = 4'd2;
   localparam logic [3:0] OPC_AND = 4'd3;
   localparam logic [3:0] OPC_OR  = 4'd4;
   localparam logic [3:0] OPC_XOR = 4'd5;
   localparam logic [3:0] OPC_SHL = 4'd6;
   localparam logic [3:0] OPC_SHR = 4'd7;
   localparam logic [3:0] OPC_MIN = 4'd8;
   localparam logic [3:0] OPC_MAX = 4'd9;

   localparam logic [1:0] SRC_FLOW = 2'd0;
   localparam logic [1:0] SRC_GLOB = 2'd1;
   localparam logic [1:0] SRC_HDR  = 2'd2;
   localparam logic [1:0] SRC_IMM  = 2'd3;

   function automatic int slot_width(int idx_w);
      return OPC_W + 2 * (TYP_W + idx_w) + 1 + idx_w;
   endfunction
endpackage

// File: rtl/flow_alu_operand.sv
module flow_alu_operand
   import flow_alu_pkg::*;
#(
   parameter int W     = 32,
   parameter int IDX_W = 4,
   parameter int NR    = 1 << IDX_W
) (
   input  logic [1:0]        typ,
   input  logic [IDX_W-1:0]  idx,
   input  logic [NR*W-1:0]   flow_vec,
   input  logic [NR*W-1:0]   glob_vec,
   input  logic [NR*W-1:0]   hdr_vec,
   output logic [W-1:0]      val
);
   always_comb begin
      case (typ)
         SRC_FLOW: val = flow_vec[int'(idx)*W +: W];
         SRC_GLOB: val = glob_vec[int'(idx)*W +: W];
         SRC_HDR:  val = hdr_vec[int'(idx)*W +: W];
         default:  val = W'(idx);
      endcase
   end
endmodule

// File: rtl/flow_alu_slot.sv
module flow_alu_slot
   import flow_alu_pkg::*;
#(
   parameter int W = 32
) (
   input  logic [3:0]   op,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] res,
   output logic         wr
);
   localparam int SH_W = $clog2(W);

   logic [SH_W-1:0] sh;
   assign sh = b[SH_W-1:0];

   always_comb begin
      wr = 1'b1;
      case (op)
         OPC_ADD: res = a + b;
         OPC_SUB: res = a - b;
         OPC_AND: res = a & b;
         OPC_OR:  res = a | b;
         OPC_XOR: res = a ^ b;
         OPC_SHL: res = a << sh;
         OPC_SHR: res = a >> sh;
         OPC_MIN: res = (a < b) ? a : b;
         OPC_MAX: res = (a < b) ? b : a;
         default: begin
            res = '0;
            wr  = 1'b0;
         end
      endcase
   end
endmodule

// File: rtl/flow_alu_merge.sv
module flow_alu_merge #(
   parameter int NS    = 4,
   parameter int W     = 32,
   parameter int IDX_W = 4,
   parameter int NR    = 1 << IDX_W,
   parameter bit GLOB  = 1'b0
) (
   input  logic [NR*W-1:0]     base,
   input  logic [NS*W-1:0]     res,
   input  logic [NS-1:0]       wr,
   input  logic [NS-1:0]       dglob,
   input  logic [NS*IDX_W-1:0] didx,
   output logic [NR*W-1:0]     merged,
   output logic [NR-1:0]       we
);
   // ascending slot order: a later slot overwrites an earlier one
   always_comb begin
      merged = base;
      we     = '0;
      for (int s = 0; s < NS; s++) begin
         if (wr[s] && (dglob[s] == GLOB)) begin
            merged[int'(didx[s*IDX_W +: IDX_W])*W +: W] = res[s*W +: W];
            we[int'(didx[s*IDX_W +: IDX_W])] = 1'b1;
         end
      end
   end
endmodule

// File: rtl/flow_alu_array.sv
module flow_alu_array
   import flow_alu_pkg::*;
#(
   parameter int NS    = 4,
   parameter int W     = 32,
   parameter int IDX_W = 4,
   localparam int NR   = 1 << IDX_W,
   localparam int IW   = slot_width(IDX_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [NS*IW-1:0]  in_instr,
   input  logic [NR*W-1:0]   flow_in,
   input  logic [NR*W-1:0]   glob_in,
   input  logic [NR*W-1:0]   hdr_in,
   output logic              out_valid,
   output logic [NR*W-1:0]   flow_out,
   output logic [NR*W-1:0]   glob_wdata,
   output logic [NR-1:0]     glob_we
);
   if (NS < 1) begin : g_bad_ns
      $error("flow_alu_array: NS must be at least 1");
   end
   if (W < 2 || (W & (W - 1)) != 0) begin : g_bad_w
      $error("flow_alu_array: W must be a power of two");
   end
   if (IDX_W < 1 || IDX_W > 6 || IDX_W > W) begin : g_bad_idx
      $error("flow_alu_array: IDX_W out of range");
   end

   // stage 1: decode and operand fetch
   logic [NS*4-1:0]     f_op;
   logic [NS*W-1:0]     f_a, f_b;
   logic [NS-1:0]       f_dglob;
   logic [NS*IDX_W-1:0] f_didx;

   for (genvar s = 0; s < NS; s++) begin : g_fetch
      logic [IW-1:0] ins;
      assign ins = in_instr[s*IW +: IW];
      assign f_op[s*4 +: 4]           = ins[IW-1 -: 4];
      assign f_dglob[s]               = ins[IDX_W];
      assign f_didx[s*IDX_W +: IDX_W] = ins[IDX_W-1:0];

      flow_alu_operand #(.W(W), .IDX_W(IDX_W), .NR(NR)) i_opa (
         .typ(ins[IW-5 -: 2]), .idx(ins[IW-7 -: IDX_W]),
         .flow_vec(flow_in), .glob_vec(glob_in), .hdr_vec(hdr_in),
         .val(f_a[s*W +: W]));
      flow_alu_operand #(.W(W), .IDX_W(IDX_W), .NR(NR)) i_opb (
         .typ(ins[IW-7-IDX_W -: 2]), .idx(ins[IW-9-IDX_W -: IDX_W]),
         .flow_vec(flow_in), .glob_vec(glob_in), .hdr_vec(hdr_in),
         .val(f_b[s*W +: W]));
   end

   logic                s1_valid;
   logic [NS*4-1:0]     s1_op;
   logic [NS*W-1:0]     s1_a, s1_b;
   logic [NS-1:0]       s1_dglob;
   logic [NS*IDX_W-1:0] s1_didx;
   logic [NR*W-1:0]     s1_flow, s1_glob;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_valid <= 1'b0;
         s1_op    <= '0;
         s1_a     <= '0;
         s1_b     <= '0;
         s1_dglob <= '0;
         s1_didx  <= '0;
         s1_flow  <= '0;
         s1_glob  <= '0;
      end else begin
         s1_valid <= in_valid;
         if (in_valid) begin
            s1_op    <= f_op;
            s1_a     <= f_a;
            s1_b     <= f_b;
            s1_dglob <= f_dglob;
            s1_didx  <= f_didx;
            s1_flow  <= flow_in;
            s1_glob  <= glob_in;
         end
      end
   end

   // stage 2: execute, resolve collisions, register
   logic [NS*W-1:0] x_res;
   logic [NS-1:0]   x_wr;

   for (genvar s = 0; s < NS; s++) begin : g_exec
      flow_alu_slot #(.W(W)) i_alu (
         .op(s1_op[s*4 +: 4]), .a(s1_a[s*W +: W]), .b(s1_b[s*W +: W]),
         .res(x_res[s*W +: W]), .wr(x_wr[s]));
   end

   logic [NR*W-1:0] m_flow, m_glob;
   logic [NR-1:0]   m_flow_we, m_glob_we;

   flow_alu_merge #(.NS(NS), .W(W), .IDX_W(IDX_W), .NR(NR), .GLOB(1'b0)) i_mflow (
      .base(s1_flow), .res(x_res), .wr(x_wr), .dglob(s1_dglob), .didx(s1_didx),
      .merged(m_flow), .we(m_flow_we));
   flow_alu_merge #(.NS(NS), .W(W), .IDX_W(IDX_W), .NR(NR), .GLOB(1'b1)) i_mglob (
      .base(s1_glob), .res(x_res), .wr(x_wr), .dglob(s1_dglob), .didx(s1_didx),
      .merged(m_glob), .we(m_glob_we));

   logic unused_flow_we;
   assign unused_flow_we = ^m_flow_we;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         flow_out   <= '0;
         glob_wdata <= '0;
         glob_we    <= '0;
      end else begin
         out_valid <= s1_valid;
         glob_we   <= s1_valid ? m_glob_we : '0;
         if (s1_valid) begin
            flow_out   <= m_flow;
            glob_wdata <= m_glob;
         end
      end
   end
endmodule

// File: rtl/flow_alu_array_chk.sv
module flow_alu_array_chk
   import flow_alu_pkg::*;
#(
   parameter int NS    = 4,
   parameter int W     = 32,
   parameter int IDX_W = 4,
   localparam int NR   = 1 << IDX_W,
   localparam int IW   = slot_width(IDX_W)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [NS*IW-1:0]  in_instr,
   input logic [NR*W-1:0]   flow_in,
   input logic [NR*W-1:0]   glob_wdata,
   input logic              out_valid,
   input logic [NR*W-1:0]   flow_out,
   input logic [NR-1:0]     glob_we
);
   function automatic logic no_writes(logic [NS*IW-1:0] b);
      logic r;
      r = 1'b1;
      for (int s = 0; s < NS; s++)
         if (b[s*IW + IW - 1 -: 4] >= 4'd1 && b[s*IW + IW - 1 -: 4] <= 4'd9) r = 1'b0;
      return r;
   endfunction

   AST_TWO_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> ##1 out_valid);  // R1
   AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(in_valid, 2));  // R1
   AST_NOP_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && no_writes($past(in_instr, 2)))
         |-> (flow_out == $past(flow_in, 2) && glob_we == '0));  // R6
   AST_WE_ONLY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> (glob_we == '0));  // R11
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> ($stable(flow_out) && $stable(glob_wdata)));  // R11
endmodule

bind flow_alu_array flow_alu_array_chk #(.NS(NS), .W(W), .IDX_W(IDX_W)) i_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_instr(in_instr),
   .flow_in(flow_in), .glob_wdata(glob_wdata), .out_valid(out_valid),
   .flow_out(flow_out), .glob_we(glob_we));

// File: tb/test_flow_alu_array.sv
`timescale 1ns/1ps
module test_flow_alu_array;
   localparam int NS = 4;
   localparam int W = 32;
   localparam int IDX_W = 4;
   localparam int NR = 16;
   localparam int IW = 21;
   localparam int STREAM = 400;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              in_valid = 1'b0;
   logic [NS*IW-1:0]  in_instr = '0;
   logic [NR*W-1:0]   flow_in = '0, glob_in = '0, hdr_in = '0;
   logic              out_valid;
   logic [NR*W-1:0]   flow_out, glob_wdata;
   logic [NR-1:0]     glob_we;

   int n_chk = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   flow_alu_array #(.NS(NS), .W(W), .IDX_W(IDX_W)) i_flow_alu_array (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_instr(in_instr),
      .flow_in(flow_in), .glob_in(glob_in), .hdr_in(hdr_in),
      .out_valid(out_valid), .flow_out(flow_out), .glob_wdata(glob_wdata),
      .glob_we(glob_we));

   task automatic check(input string req, input string what,
                        input logic [NR*W-1:0] act, input logic [NR*W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic [IW-1:0] mk(input logic [3:0] op, input logic [1:0] ta,
         input logic [3:0] ia, input logic [1:0] tb, input logic [3:0] ib,
         input logic dg, input logic [3:0] di);
      return {op, ta, ia, tb, ib, dg, di};
   endfunction

   function automatic logic [W-1:0] opnd(input logic [1:0] t, input logic [3:0] i,
         input logic [NR*W-1:0] fl, input logic [NR*W-1:0] gl, input logic [NR*W-1:0] hd);
      case (t)
         2'd0: return fl[int'(i)*W +: W];
         2'd1: return gl[int'(i)*W +: W];
         2'd2: return hd[int'(i)*W +: W];
         default: return {28'd0, i};
      endcase
   endfunction

   task automatic model(input logic [NS*IW-1:0] ins, input logic [NR*W-1:0] fl,
         input logic [NR*W-1:0] gl, input logic [NR*W-1:0] hd,
         output logic [NR*W-1:0] ef, output logic [NR*W-1:0] eg, output logic [NR-1:0] ewe);
      ef = fl; eg = gl; ewe = '0;
      for (int s = 0; s < NS; s++) begin
         logic [IW-1:0] x;
         logic [W-1:0] a, b, r;
         logic ok;
         x = ins[s*IW +: IW];
         a = opnd(x[16:15], x[14:11], fl, gl, hd);
         b = opnd(x[10:9], x[8:5], fl, gl, hd);
         ok = 1'b1;
         case (x[20:17])
            4'd1: r = a + b;
            4'd2: r = a - b;
            4'd3: r = a & b;
            4'd4: r = a | b;
            4'd5: r = a ^ b;
            4'd6: r = a << b[4:0];
            4'd7: r = a >> b[4:0];
            4'd8: r = (a < b) ? a : b;
            4'd9: r = (a > b) ? a : b;
            default: begin r = '0; ok = 1'b0; end
         endcase
         if (ok) begin
            if (x[4]) begin
               eg[int'(x[3:0])*W +: W] = r;
               ewe[int'(x[3:0])] = 1'b1;
            end else begin
               ef[int'(x[3:0])*W +: W] = r;
            end
         end
      end
   endtask

   function automatic logic [W-1:0] rword();
      case ($urandom % 4)
         0: return 32'hFFFF_FFFF;
         1: return 32'd0;
         default: return $urandom;
      endcase
   endfunction

   function automatic logic [3:0] ridx();
      if ($urandom % 2 == 0) return 4'($urandom % 4);
      return 4'($urandom % 16);
   endfunction

   task automatic rand_regs();
      for (int i = 0; i < NR; i++) begin
         flow_in[i*W +: W] = rword();
         glob_in[i*W +: W] = rword();
         hdr_in[i*W +: W]  = rword();
      end
   endtask

   // one isolated packet: drive, check latency, results, then idle hold
   task automatic run_pkt(input string req, input logic [NS*IW-1:0] ins);
      logic [NR*W-1:0] ef, eg;
      logic [NR-1:0] ewe;
      model(ins, flow_in, glob_in, hdr_in, ef, eg, ewe);
      in_instr = ins;
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check("R1", "valid after one edge", {511'd0, out_valid}, '0);
      @(negedge clk);
      check("R1", "valid after two edges", {511'd0, out_valid}, {511'd0, 1'b1});
      check(req, "flow_out", flow_out, ef);
      check(req, "glob_wdata", glob_wdata, eg);
      check(req, "glob_we", {496'd0, glob_we}, {496'd0, ewe});
      @(negedge clk);
      check("R11", "valid low when idle", {511'd0, out_valid}, '0);
      check("R11", "glob_we idle", {496'd0, glob_we}, '0);
      check("R11", "flow_out held", flow_out, ef);
   endtask

   initial begin
      #(5.0 * 150000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic [NS*IW-1:0] ins;
      logic [W-1:0] f3;
      logic [NR*W-1:0] lf, lg;
      logic          ev [3];
      logic [NR*W-1:0] efa [3];
      logic [NR*W-1:0] ega [3];
      logic [NR-1:0]   ewa [3];
      void'($urandom(32'd4242));

      repeat (4) @(negedge clk);
      check("R12", "valid in reset", {511'd0, out_valid}, '0);
      check("R12", "flow_out in reset", flow_out, '0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R12", "flow_out after reset", flow_out, '0);
      check("R12", "glob_wdata after reset", glob_wdata, '0);
      check("R12", "glob_we after reset", {496'd0, glob_we}, '0);

      // R4: wraparound of ADD and SUB, field layout of R2
      rand_regs();
      flow_in[0*W +: W] = 32'hFFFF_FFFF;
      ins = {mk(4'd0, 2'd0, 4'd0, 2'd0, 4'd0, 1'b0, 4'd0),
             mk(4'd0, 2'd0, 4'd0, 2'd0, 4'd0, 1'b0, 4'd0),
             mk(4'd2, 2'd3, 4'd0, 2'd3, 4'd1, 1'b1, 4'd2),
             mk(4'd1, 2'd0, 4'd0, 2'd3, 4'd1, 1'b0, 4'd1)};
      run_pkt("R4", ins);
      check("R4", "ADD wrap to zero", {480'd0, flow_out[1*W +: W]}, '0);
      check("R4", "SUB wrap", {480'd0, glob_wdata[2*W +: W]}, {480'd0, 32'hFFFF_FFFF});

      // R5: AND, SHL by header value 33, MIN, MAX
      rand_regs();
      hdr_in[1*W +: W] = 32'd33;
      ins = {mk(4'd9, 2'd0, 4'd2, 2'd1, 4'd3, 1'b1, 4'd1),
             mk(4'd8, 2'd0, 4'd2, 2'd1, 4'd3, 1'b1, 4'd0),
             mk(4'd6, 2'd0, 4'd2, 2'd2, 4'd1, 1'b0, 4'd6),
             mk(4'd3, 2'd0, 4'd2, 2'd1, 4'd3, 1'b0, 4'd5)};
      f3 = flow_in[2*W +: W];
      run_pkt("R5", ins);
      check("R5", "SHL uses low 5 bits", {480'd0, flow_out[6*W +: W]}, {480'd0, f3 << 1});

      // R5: OR, XOR, SHR, and R3 operand kinds
      rand_regs();
      ins = {mk(4'd7, 2'd2, 4'd4, 2'd3, 4'd15, 1'b0, 4'd9),
             mk(4'd5, 2'd1, 4'd7, 2'd2, 4'd8, 1'b1, 4'd7),
             mk(4'd4, 2'd2, 4'd0, 2'd3, 4'd9, 1'b0, 4'd0),
             mk(4'd1, 2'd3, 4'd12, 2'd3, 4'd3, 1'b0, 4'd15)};
      run_pkt("R3", ins);
      check("R3", "immediate sum", {480'd0, flow_out[15*W +: W]}, {480'd0, 32'd15});

      // R9 and R10: collision on a global, read of a register being written
      rand_regs();
      f3 = flow_in[3*W +: W];
      ins = {mk(4'd1, 2'd3, 4'd9, 2'd3, 4'd0, 1'b1, 4'd5),
             mk(4'd4, 2'd3, 4'd5, 2'd3, 4'd0, 1'b1, 4'd5),
             mk(4'd1, 2'd0, 4'd3, 2'd3, 4'd0, 1'b0, 4'd4),
             mk(4'd1, 2'd0, 4'd3, 2'd3, 4'd1, 1'b0, 4'd3)};
      run_pkt("R9", ins);
      check("R9", "highest slot wins", {480'd0, glob_wdata[5*W +: W]}, {480'd0, 32'd9});
      check("R10", "reader sees old value", {480'd0, flow_out[4*W +: W]}, {480'd0, f3});
      check("R7", "writer updated", {480'd0, flow_out[3*W +: W]}, {480'd0, f3 + 32'd1});

      // R6: NOP and unused opcodes
      rand_regs();
      ins = {mk(4'd15, 2'd0, 4'd1, 2'd0, 4'd2, 1'b1, 4'd3),
             mk(4'd12, 2'd1, 4'd1, 2'd0, 4'd2, 1'b0, 4'd3),
             mk(4'd10, 2'd0, 4'd1, 2'd0, 4'd2, 1'b1, 4'd4),
             mk(4'd0, 2'd0, 4'd1, 2'd0, 4'd2, 1'b0, 4'd4)};
      lf = flow_in;
      run_pkt("R6", ins);
      check("R6", "flow unchanged", flow_out, lf);
      check("R8", "unwritten global passes", glob_wdata, glob_in);

      // random stream, back to back packets (R1, R7, R8, R9, R10, R11)
      lf = flow_out;
      lg = glob_wdata;
      for (int k = 0; k < STREAM + 2; k++) begin
         @(negedge clk);
         if (k >= 2) begin
            int j;
            j = (k - 2) % 3;
            check("R1", "stream valid", {511'd0, out_valid}, {511'd0, ev[j]});
            check("R7", "stream flow_out", flow_out, efa[j]);
            check("R8", "stream glob_wdata", glob_wdata, ega[j]);
            check("R9", "stream glob_we", {496'd0, glob_we}, {496'd0, ewa[j]});
         end
         if (k < STREAM) begin
            int j;
            j = k % 3;
            rand_regs();
            for (int s = 0; s < NS; s++)
               ins[s*IW +: IW] = mk(4'($urandom % 16), 2'($urandom % 4), ridx(),
                                    2'($urandom % 4), ridx(), 1'($urandom % 2), ridx());
            in_instr = ins;
            in_valid = (k == 0) || ($urandom % 4 != 0);
            ev[j] = in_valid;
            if (in_valid) begin
               model(ins, flow_in, glob_in, hdr_in, efa[j], ega[j], ewa[j]);
               lf = efa[j];
               lg = ega[j];
            end else begin
               efa[j] = lf;
               ega[j] = lg;
               ewa[j] = '0;
            end
         end else begin
            in_valid = 1'b0;
         end
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule